// File: doc/BRIEF.md
# UART Receiver with Per-Character Status

This block receives asynchronous serial characters on a single line and holds the most recent one in a one-entry buffer. Status flags describe that character. A baud tick counter reloads from a 12-bit divisor and produces one tick every `baud_div + 1` clocks. Each bit lasts 16 ticks in normal speed, or 8 ticks when double speed is selected. A falling edge on the line begins a frame. The receiver then takes three samples around the middle of each bit and keeps the majority value.

A frame carries 8 data bits. In multiprocessor mode a ninth bit follows the data and marks address frames. A parity bit can be added, and a stop bit closes the frame. The frame-error and parity-error flags are stored with the character they belong to. If a new character completes while the buffer is still unread, the overrun flag is raised. In multiprocessor mode, frames whose ninth bit is 0 are discarded without any trace, so a host can skip traffic meant for other nodes. A read strobe consumes the buffered character and clears the flags.

Top module: `uart_rx_status`

## Requirements
- R1: A baud tick occurs once every `baud_div + 1` clocks. One bit spans 16 ticks when `dbl_speed` = 0 and 8 ticks when `dbl_speed` = 1.
- R2: A frame has the following bits in order:
  - a low start bit;
  - 8 data bits, least significant first;
  - a ninth bit, present only when `mp_mode` = 1;
  - a parity bit, present only when `par_mode[1]` = 1;
  - a stop bit.

  Each bit value is the majority of three samples taken at ticks mid-1, mid and mid+1 of the bit. The character is complete at the mid+1 sample of the stop bit.
- R3: A start candidate is taken on a tick where the line is low after having been seen high while idle. If its majority vote is high, the receiver returns to idle, stores nothing, and waits for a new high-to-low transition. A low pulse shorter than half a bit is therefore ignored.
- R4: After reset, and whenever the buffer is empty, `rx_full`, `err_frame`, `err_parity` and `err_overrun` are 0. A stored character appears on `rx_data` with `rx_full` = 1.
- R5: `err_frame` is stored with the character and is 1 when that character's stop bit voted low.
- R6: `par_mode` selects the parity check:
  - 00 or 01: none;
  - 10: even;
  - 11: odd.

  Parity covers the 8 data bits plus the ninth bit when present. `err_parity` is stored with the character and is 1 on a mismatch.
- R7: A `rd_strobe` cycle while `rx_full` = 1 clears `rx_full`, `err_frame`, `err_parity` and `err_overrun` at the next edge.
- R8: If a character completes while `rx_full` = 1 and no read occurs in that cycle, `err_overrun` becomes 1. The new character is discarded, and `rx_data` keeps the old one.
- R9: When `mp_mode` = 1, a completed frame whose ninth bit is 0 is discarded. It changes neither `rx_full` nor `err_overrun`.
- R10: While `rx_en` = 0 the receiver stays idle and stores nothing.
- R11: If a read and a character completion occur in the same cycle, the old character is consumed and the new one is stored. `rx_full` stays 1 and `err_overrun` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Serial line, idle high |
| baud_div | input | 12 | Tick period minus one, in clocks |
| rx_en | input | 1 | Receiver enable |
| dbl_speed | input | 1 | 1 selects 8 ticks per bit, 0 selects 16 |
| par_mode | input | 2 | Parity selection (see R6) |
| mp_mode | input | 1 | Multiprocessor (address filter) mode |
| rd_strobe | input | 1 | Consume the buffered character |
| rx_data | output | 8 | Buffered character |
| rx_full | output | 1 | Unread character present |
| err_frame | output | 1 | Stop bit of buffered character was low |
| err_parity | output | 1 | Parity mismatch on buffered character |
| err_overrun | output | 1 | A character was lost while the buffer was full |

## Verification
A host read and the completion of a new character can land on the same clock edge. That edge decides whether the buffer reports an overrun or takes the new character cleanly. The bench fills the buffer, then sends a second character at divisor 0 and double speed, where the store edge can be counted from the first start-bit drive. It pulses the read strobe exactly on that edge. The result is judged on both sides of the edge: one cycle before, the old character must still be held with no overrun; one cycle after, the new character must be held with `rx_full` high and no overrun. Separate runs place the read well before and well after completion, and each must produce its own outcome.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int RX_DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_NINTH,
    ST_PARITY,
    ST_STOP
  } rx_state_t;

  typedef struct packed {
    logic [RX_DATA_W-1:0] data;
    logic                 ninth;
    logic                 frame_err;
    logic                 par_err;
  } rx_char_t;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == '0) begin
      cnt  <= div;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt - 1'b1;
      tick <= 1'b0;
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
    (tick && en && div != '0 && $stable(div)) |=> !tick) else $error("tick gap"); // R1

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OS_NORM = 16,
  parameter int OS_FAST = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       tick,
  input  logic       rx_i,
  input  logic       dbl,
  input  logic [1:0] par_mode,
  input  logic       mp_mode,
  output logic       done,
  output rx_char_t   char_o
);

  localparam int CW = $clog2(OS_NORM);
  localparam int BW = $clog2(RX_DATA_W);

  logic                 rx_m, rx_s;
  rx_state_t            state, after_data, after_ninth;
  logic [CW-1:0]        cnt, os_last, mid, mid_lo, mid_hi;
  logic [BW-1:0]        bitn;
  logic [RX_DATA_W-1:0] shreg;
  logic [1:0]           smp;
  logic                 armed, ninth_q, par_q, vote, ninth_eff, pe_calc, par_on;

  // two-flop line synchronizer, idle high
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rx_i;
      rx_s <= rx_m;
    end
  end

  always_comb begin
    os_last     = dbl ? CW'(OS_FAST - 1) : CW'(OS_NORM - 1);
    mid         = dbl ? CW'(OS_FAST / 2) : CW'(OS_NORM / 2);
    mid_lo      = mid - 1'b1;
    mid_hi      = mid + 1'b1;
    vote        = vote3(smp[0], smp[1], rx_s);
    par_on      = par_mode[1];
    ninth_eff   = mp_mode & ninth_q;
    pe_calc     = par_on && ((^shreg ^ ninth_eff ^ par_q) != par_mode[0]);
    after_data  = mp_mode ? ST_NINTH : (par_on ? ST_PARITY : ST_STOP);
    after_ninth = par_on ? ST_PARITY : ST_STOP;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      armed   <= 1'b0;
      smp     <= '0;
      bitn    <= '0;
      shreg   <= '0;
      ninth_q <= 1'b0;
      par_q   <= 1'b0;
      done    <= 1'b0;
      char_o  <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        if (state == ST_IDLE) begin
          if (rx_s) begin
            armed <= 1'b1;
          end else if (armed) begin
            state   <= ST_START;
            cnt     <= CW'(1);
            armed   <= 1'b0;
            ninth_q <= 1'b0;
          end
        end else begin
          cnt <= (cnt == os_last) ? '0 : cnt + 1'b1;
          if (cnt == mid_lo) smp[0] <= rx_s;
          if (cnt == mid)    smp[1] <= rx_s;
          case (state)
            ST_START: begin
              if (cnt == mid_hi && vote) begin
                state <= ST_IDLE;
              end else if (cnt == os_last) begin
                state <= ST_DATA;
                bitn  <= '0;
              end
            end
            ST_DATA: begin
              if (cnt == mid_hi) begin
                shreg <= {vote, shreg[RX_DATA_W-1:1]};
              end else if (cnt == os_last) begin
                if (bitn == BW'(RX_DATA_W - 1)) state <= after_data;
                else                            bitn  <= bitn + 1'b1;
              end
            end
            ST_NINTH: begin
              if (cnt == mid_hi)       ninth_q <= vote;
              else if (cnt == os_last) state   <= after_ninth;
            end
            ST_PARITY: begin
              if (cnt == mid_hi)       par_q <= vote;
              else if (cnt == os_last) state <= ST_STOP;
            end
            ST_STOP: begin
              if (cnt == mid_hi) begin
                done             <= 1'b1;
                char_o.data      <= shreg;
                char_o.ninth     <= ninth_eff;
                char_o.frame_err <= !vote;
                char_o.par_err   <= pe_calc;
                state            <= ST_IDLE;
              end
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end

  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> (state == ST_IDLE && !done)) else $error("not idle when off"); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done not a pulse"); // R2
  AST_GLITCH_IDLE: assert property (@(posedge clk) disable iff (rst || !en)
    (tick && state == ST_START && cnt == mid_hi && vote) |=> (state == ST_IDLE && !done))
    else $error("glitch accepted"); // R3

endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf
  import uart_rx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 done,
  input  rx_char_t             char_i,
  input  logic                 mp_mode,
  input  logic                 rd,
  output logic [RX_DATA_W-1:0] data,
  output logic                 full,
  output logic                 fe,
  output logic                 pe,
  output logic                 ovr
);

  logic accept;

  always_comb accept = done && (!mp_mode || char_i.ninth);

  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
      full <= 1'b0;
      fe   <= 1'b0;
      pe   <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      if (rd && full) begin
        full <= 1'b0;
        fe   <= 1'b0;
        pe   <= 1'b0;
        ovr  <= 1'b0;
      end
      if (accept) begin
        if (full && !rd) begin
          ovr <= 1'b1;
        end else begin
          data <= char_i.data;
          fe   <= char_i.frame_err;
          pe   <= char_i.par_err;
          full <= 1'b1;
        end
      end
    end
  end

  AST_EMPTY_CLEAN: assert property (@(posedge clk) disable iff (rst)
    !full |-> !(fe || pe || ovr)) else $error("flags without char"); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd && full && !accept) |=> (!full && !ovr && !fe && !pe)) else $error("read"); // R7
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (rst)
    (accept && full && !rd) |=> (ovr && full && $stable(data))) else $error("overrun"); // R8
  AST_MP_DROP: assert property (@(posedge clk) disable iff (rst)
    (done && mp_mode && !char_i.ninth && !rd) |=> ($stable(full) && $stable(ovr)))
    else $error("mp drop"); // R9
  AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (accept && rd && full) |=> (full && !ovr)) else $error("same cycle"); // R11

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int DIV_W   = 12,
  parameter int OS_NORM = 16,
  parameter int OS_FAST = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_i,
  input  logic [DIV_W-1:0]     baud_div,
  input  logic                 rx_en,
  input  logic                 dbl_speed,
  input  logic [1:0]           par_mode,
  input  logic                 mp_mode,
  input  logic                 rd_strobe,
  output logic [RX_DATA_W-1:0] rx_data,
  output logic                 rx_full,
  output logic                 err_frame,
  output logic                 err_parity,
  output logic                 err_overrun
);

  logic     tick, done;
  rx_char_t char_w;

  uart_rx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk  (clk),
    .rst  (rst),
    .en   (rx_en),
    .div  (baud_div),
    .tick (tick)
  );

  uart_rx_frame #(.OS_NORM(OS_NORM), .OS_FAST(OS_FAST)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .en       (rx_en),
    .tick     (tick),
    .rx_i     (rx_i),
    .dbl      (dbl_speed),
    .par_mode (par_mode),
    .mp_mode  (mp_mode),
    .done     (done),
    .char_o   (char_w)
  );

  uart_rx_buf u_buf (
    .clk     (clk),
    .rst     (rst),
    .done    (done),
    .char_i  (char_w),
    .mp_mode (mp_mode),
    .rd      (rd_strobe),
    .data    (rx_data),
    .full    (rx_full),
    .fe      (err_frame),
    .pe      (err_parity),
    .ovr     (err_overrun)
  );

endmodule

// File: tb/test_uart_rx_status.sv
module test_uart_rx_status;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx = 1'b1;
  logic [11:0] div = 12'd0;
  logic        en = 1'b1;
  logic        dbl = 1'b1;
  logic [1:0]  pm = 2'b00;
  logic        mp = 1'b0;
  logic        rd = 1'b0;
  logic [7:0]  rx_data;
  logic        rx_full, err_frame, err_parity, err_overrun;

  int n_cmp = 0;
  int n_mis = 0;

  always #10 clk = ~clk;

  uart_rx_status i_uart_rx_status (
    .clk(clk), .rst(rst), .rx_i(rx), .baud_div(div), .rx_en(en),
    .dbl_speed(dbl), .par_mode(pm), .mp_mode(mp), .rd_strobe(rd),
    .rx_data(rx_data), .rx_full(rx_full), .err_frame(err_frame),
    .err_parity(err_parity), .err_overrun(err_overrun)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int bit_clks();
    return (dbl ? 8 : 16) * (int'(div) + 1);
  endfunction

  task automatic drive_bit(input logic b);
    @(negedge clk) rx = b;
    repeat (bit_clks() - 1) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic nine, input logic pbit,
                      input logic stopb);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (mp) drive_bit(nine);
    if (pm[1]) drive_bit(pbit);
    drive_bit(stopb);
    @(negedge clk) rx = 1'b1;
    repeat (int'(div) + 6) @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_mis++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R4: reset state
    check("R4 reset full", rx_full, 0);
    check("R4 reset flags", {err_frame, err_parity, err_overrun}, 0);

    // R2 R6: sweep every data value across parity modes, fast mode, div 0
    for (int v = 0; v < 256; v++) begin
      logic [7:0] d;
      logic pbit, exp_pe;
      d = 8'(v);
      case (v % 3)
        0: pm = 2'b00;
        1: pm = 2'b10;
        default: pm = 2'b11;
      endcase
      pbit = (pm == 2'b11) ? ~^d : ^d;
      exp_pe = 1'b0;
      if (pm[1] && (v % 5 == 0)) begin
        pbit = ~pbit;
        exp_pe = 1'b1;
      end
      send(d, 1'b0, pbit, 1'b1);
      check("R4 full after frame", rx_full, 1);
      check("R2 data", rx_data, d);
      check("R6 parity flag", err_parity, exp_pe);
      check("R5 no frame error", err_frame, 0);
      do_read();
      check("R7 full cleared", rx_full, 0);
      check("R7 parity cleared", err_parity, 0);
    end
    pm = 2'b00;

    // R1: divisor 3 in both speeds
    div = 12'd3;
    for (int s = 0; s < 2; s++) begin
      dbl = s[0];
      for (int k = 0; k < 6; k++) begin
        logic [7:0] d;
        d = 8'(37 * k + 11 * s + 5);
        send(d, 1'b0, 1'b0, 1'b1);
        check("R1 data at divisor 3", rx_data, d);
        check("R1 full", rx_full, 1);
        do_read();
      end
    end
    div = 12'd0;
    dbl = 1'b1;
    repeat (4) @(negedge clk);

    // R5: bad stop bit, then recovery
    send(8'h5A, 1'b0, 1'b0, 1'b0);
    check("R5 full", rx_full, 1);
    check("R5 frame error", err_frame, 1);
    check("R5 data", rx_data, 8'h5A);
    do_read();
    check("R5 frame error cleared", err_frame, 0);
    send(8'h3C, 1'b0, 1'b0, 1'b1);
    check("R5 recovery data", rx_data, 8'h3C);
    check("R5 recovery clean", err_frame, 0);
    do_read();

    // R3: short low pulses are rejected
    for (int w = 1; w <= 3; w++) begin
      @(negedge clk) rx = 1'b0;
      repeat (w - 1) @(negedge clk);
      @(negedge clk) rx = 1'b1;
      repeat (100) @(negedge clk);
      check("R3 glitch ignored", rx_full, 0);
    end
    send(8'hA5, 1'b0, 1'b0, 1'b1);
    check("R3 frame after glitch", rx_data, 8'hA5);
    check("R3 full after glitch", rx_full, 1);
    do_read();

    // R8: overrun
    send(8'h11, 1'b0, 1'b0, 1'b1);
    send(8'h22, 1'b0, 1'b0, 1'b1);
    check("R8 overrun set", err_overrun, 1);
    check("R8 old data kept", rx_data, 8'h11);
    check("R8 still full", rx_full, 1);
    do_read();
    check("R7 overrun cleared", err_overrun, 0);
    check("R7 empty", rx_full, 0);

    // R9: multiprocessor filtering
    mp = 1'b1;
    send(8'h33, 1'b0, 1'b0, 1'b1);
    check("R9 data frame dropped", rx_full, 0);
    send(8'h44, 1'b1, 1'b0, 1'b1);
    check("R9 address stored", rx_data, 8'h44);
    check("R9 address full", rx_full, 1);
    send(8'h55, 1'b0, 1'b0, 1'b1);
    check("R9 no overrun from dropped", err_overrun, 0);
    check("R9 data kept", rx_data, 8'h44);
    do_read();
    mp = 1'b0;

    // R10: disabled receiver
    en = 1'b0;
    send(8'h66, 1'b0, 1'b0, 1'b1);
    check("R10 nothing stored", rx_full, 0);
    en = 1'b1;
    repeat (4) @(negedge clk);
    send(8'h77, 1'b0, 1'b0, 1'b1);
    check("R10 enabled again", rx_data, 8'h77);
    do_read();

    // R11: read on the completion edge (store edge is the 81st edge after start drive)
    send(8'h81, 1'b0, 1'b0, 1'b1);
    fork
      send(8'h82, 1'b0, 1'b0, 1'b1);
      begin
        @(negedge clk);
        repeat (80) @(posedge clk);
        @(negedge clk);
        check("R11 before edge data", rx_data, 8'h81);
        check("R11 before edge overrun", err_overrun, 0);
        rd = 1'b1;
        @(negedge clk) rd = 1'b0;
        check("R11 after edge full", rx_full, 1);
        check("R11 after edge data", rx_data, 8'h82);
        check("R11 after edge overrun", err_overrun, 0);
      end
    join
    do_read();

    // R11 contrast: read well before and well after completion
    send(8'h90, 1'b0, 1'b0, 1'b1);
    fork
      send(8'h91, 1'b0, 1'b0, 1'b1);
      begin
        @(negedge clk);
        repeat (40) @(posedge clk);
        do_read();
      end
    join
    check("R11 early read new data", rx_data, 8'h91);
    check("R11 early read no overrun", err_overrun, 0);
    do_read();
    send(8'hA0, 1'b0, 1'b0, 1'b1);
    send(8'hA1, 1'b0, 1'b0, 1'b1);
    check("R8 late read overrun", err_overrun, 1);
    do_read();
    check("R7 late read clears", {rx_full, err_overrun}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

endmodule